// File: doc/BRIEF.md
# Front Panel Button Interrupt Register

This block watches three push buttons on a front panel: power, volume up and volume down. All three are active low and asynchronous to the core clock. Each input is synchronized and turned into one-cycle press and release pulses. The pulses update an 8-bit panel status register. That register holds a sticky event flag per button, a live hold flag per volume button and a power-state flag.

While any event flag is set, the block drives an interrupt request toward the system interrupt controller. Software reads the register over a byte-wide bus. It acknowledges events by writing ones to the flags it has handled, and the request drops once no event flag is left.

Top module: `panel_irq_reg`

## Requirements
- R1: After reset, the register reads 0xA1 and the request is low: volume-up hold (bit 7), volume-down hold (bit 5) and power state (bit 0) are set, and every other bit is clear.
- R2: A volume-button press (input going 0) sets that button's event flag and clears its hold flag. The flags are bit 6 event / bit 7 hold for volume up and bit 4 event / bit 5 hold for volume down. The change is visible after the third rising clock edge following the input change.
- R3: A volume-button release sets that button's hold flag again and leaves its event flag unchanged.
- R4: A power-button press sets the power event flag (bit 1), and a power-button release clears it.
- R5: A write with the write enable high clears each event flag (bits 6, 4, 1) whose data bit is 1. Hold flags, power state and bits 3:2 do not change, whatever the data.
- R6: The request is high exactly while at least one of bits 6, 4 and 1 is set. It changes in the same cycle as the register, so a partial acknowledge leaves it high.
- R7: If a press pulse and a write that clears the same event flag reach the register in the same cycle, the press wins and the flag stays set.
- R8: Bits 3:2 always read 0, and power state (bit 0) always reads 1. Reading has no side effect.
- R9: Only edges create events: a button held down after its event was acknowledged does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_btn_n | input | 1 | Power button, 0 while pressed, asynchronous |
| vup_btn_n | input | 1 | Volume-up button, 0 while pressed, asynchronous |
| vdn_btn_n | input | 1 | Volume-down button, 0 while pressed, asynchronous |
| wr_en | input | 1 | Write strobe for the acknowledge write |
| wr_data | input | 8 | Write data; ones clear the matching event flags |
| rd_data | output | 8 | Current panel register contents |
| irq | output | 1 | Panel interrupt request |

## Verification
The results of a button change cross two synchronizer flops and one edge flop, so they appear in the register and on the request after the third rising edge. A write takes effect after the first rising edge. The bench drives inputs on falling edges and samples on falling edges. Table steps wait five cycles before checking, which is past every latency. Directed tests check the exact cycle of a press: unchanged after one and two edges, updated after three. The collision test raises the write strobe in the one cycle where the press pulse reaches the register.

// File: rtl/panel_pkg.sv
// Shared constants for the front panel register: bit map, reset value,
// button indices. Bit positions are decoded by software, so they are fixed.
package panel_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_BTN = 3;

    // Button indices in the packed button vectors
    localparam int BTN_PWR = 0;
    localparam int BTN_VUP = 1;
    localparam int BTN_VDN = 2;

    // Register bit positions
    localparam int B_VUP_HOLD = 7;
    localparam int B_VUP_EVT  = 6;
    localparam int B_VDN_HOLD = 5;
    localparam int B_VDN_EVT  = 4;
    localparam int B_PWR_EVT  = 1;
    localparam int B_PWR_ST   = 0;

    localparam logic [REG_W-1:0] EVT_MASK  = 8'h52;
    localparam logic [REG_W-1:0] RESET_VAL = 8'hA1;
endpackage

// File: rtl/panel_btn_sync.sv
// Button synchronizer and edge detector.
// Brings one asynchronous active-low button into the clock domain through
// STAGES flops, then compares with one more flop to emit single-cycle press
// (1->0) and release (0->1) pulses. Assumes STAGES >= 2 and that the
// input is already debounced. All flops reset to "released".
module panel_btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic press,
    output logic release_p
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] chain;
    logic         prev;

    // Synchronizer shift chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[MSB-1:0], btn_n};
    end

    // Delayed copy of the synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[MSB];
    end

    // Edge pulses from synchronized level vs. its delayed copy
    always_comb begin
        press     = prev & ~chain[MSB];
        release_p = ~prev & chain[MSB];
    end

    // R2: a press pulse lasts exactly one cycle
    assert_press_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);
    // R3: a release pulse lasts exactly one cycle
    assert_release_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        release_p |=> !release_p);
endmodule

// File: rtl/panel_evt_core.sv
// Panel status register core.
// Holds the sticky event flags, the volume hold flags and the power-state
// flag, and applies press/release pulses and write-one-to-clear writes.
// Assumes press/release pulses are single-cycle and synchronous.
// A press beats a same-cycle clearing write on the same flag.
module panel_evt_core
    import panel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BTN-1:0] press,
    input  logic [NUM_BTN-1:0] release_p,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   panel_q
);
    logic [REG_W-1:0] q_nxt;
    logic [REG_W-1:0] clr;

    // Register state update
    always_ff @(posedge clk) begin
        if (!rst_n) panel_q <= RESET_VAL;
        else        panel_q <= q_nxt;
    end

    // Next-state logic: set on press, clear on write, holds track edges
    always_comb begin
        clr   = wr_en ? (wr_data & EVT_MASK) : '0;
        q_nxt = panel_q;

        q_nxt[B_VUP_EVT] = press[BTN_VUP] | (panel_q[B_VUP_EVT] & ~clr[B_VUP_EVT]);
        q_nxt[B_VDN_EVT] = press[BTN_VDN] | (panel_q[B_VDN_EVT] & ~clr[B_VDN_EVT]);
        q_nxt[B_PWR_EVT] = press[BTN_PWR] |
                           (panel_q[B_PWR_EVT] & ~clr[B_PWR_EVT] & ~release_p[BTN_PWR]);

        if (press[BTN_VUP])          q_nxt[B_VUP_HOLD] = 1'b0;
        else if (release_p[BTN_VUP]) q_nxt[B_VUP_HOLD] = 1'b1;

        if (press[BTN_VDN])          q_nxt[B_VDN_HOLD] = 1'b0;
        else if (release_p[BTN_VDN]) q_nxt[B_VDN_HOLD] = 1'b1;

        q_nxt[3:2]      = 2'b00;
        q_nxt[B_PWR_ST] = panel_q[B_PWR_ST];
    end

    // R2: press sets event and clears hold
    assert_vup_press_R2: assert property (@(posedge clk) disable iff (!rst_n)
        press[BTN_VUP] |=> (panel_q[B_VUP_EVT] && !panel_q[B_VUP_HOLD]));
    assert_vdn_press_R2: assert property (@(posedge clk) disable iff (!rst_n)
        press[BTN_VDN] |=> (panel_q[B_VDN_EVT] && !panel_q[B_VDN_HOLD]));
    // R3: release restores hold, keeps event
    assert_vup_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (release_p[BTN_VUP] && !wr_en) |=>
            (panel_q[B_VUP_HOLD] && $stable(panel_q[B_VUP_EVT])));
    // R4: power press sets, release clears
    assert_pwr_press_R4: assert property (@(posedge clk) disable iff (!rst_n)
        press[BTN_PWR] |=> panel_q[B_PWR_EVT]);
    assert_pwr_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        release_p[BTN_PWR] |=> !panel_q[B_PWR_EVT]);
    // R5: a clearing write without a press empties the flag
    assert_w1c_vdn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_VDN_EVT] && !press[BTN_VDN]) |=> !panel_q[B_VDN_EVT]);
    // R5: writes leave hold flags alone
    assert_w1c_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !press[BTN_VUP] && !release_p[BTN_VUP]) |=> $stable(panel_q[B_VUP_HOLD]));
    // R7: press beats clearing write
    assert_press_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (press[BTN_VUP] && wr_en && wr_data[B_VUP_EVT]) |=> panel_q[B_VUP_EVT]);
    // R9: no event without an edge
    assert_edge_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!press[BTN_VDN] && !panel_q[B_VDN_EVT]) |=> !panel_q[B_VDN_EVT]);
endmodule

// File: rtl/panel_irq_reg.sv
// Front panel button interrupt register, top level.
// Synchronizes the three buttons (one generated instance each), feeds the
// pulses into the register core and drives the request from the event
// flags. Assumes debounced buttons; reset is synchronous and active low.
module panel_irq_reg
    import panel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_btn_n,
    input  logic             vup_btn_n,
    input  logic             vdn_btn_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);
    logic [NUM_BTN-1:0] btn_n;
    logic [NUM_BTN-1:0] press;
    logic [NUM_BTN-1:0] release_p;
    logic [REG_W-1:0]   panel_q;

    // Pack the buttons by index
    always_comb begin
        btn_n[BTN_PWR] = pwr_btn_n;
        btn_n[BTN_VUP] = vup_btn_n;
        btn_n[BTN_VDN] = vdn_btn_n;
    end

    for (genvar i = 0; i < NUM_BTN; i++) begin : g_sync
        panel_btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .btn_n    (btn_n[i]),
            .press    (press[i]),
            .release_p(release_p[i])
        );
    end

    panel_evt_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .press    (press),
        .release_p(release_p),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .panel_q  (panel_q)
    );

    // Read path and request from the event flags
    always_comb begin
        rd_data = panel_q;
        irq     = |(panel_q & EVT_MASK);
    end

    // R6: request only rises after a press pulse
    assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|press));
    // R6: request only falls after a write or a power release
    assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(wr_en) || $past(release_p[BTN_PWR])));
endmodule

// File: tb/tb_panel_irq_reg.sv
`timescale 1ns/1ps
module tb_panel_irq_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_btn_n = 1'b1, vup_btn_n = 1'b1, vdn_btn_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    panel_irq_reg dut (
        .clk(clk), .rst_n(rst_n),
        .pwr_btn_n(pwr_btn_n), .vup_btn_n(vup_btn_n), .vdn_btn_n(vdn_btn_n),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    // Vector: {btn{pwr,vup,vdn}[20:18], wr_en[17], wr_data[16:9], exp_reg[8:1], exp_irq[0]}
    localparam logic [20:0] VEC [0:15] = '{
        {3'b111, 1'b0, 8'h00, 8'hA1, 1'b0},  // idle
        {3'b101, 1'b0, 8'h00, 8'h61, 1'b1},  // R2 vol-up press
        {3'b111, 1'b0, 8'h00, 8'hE1, 1'b1},  // R3 vol-up release
        {3'b111, 1'b1, 8'h40, 8'hA1, 1'b0},  // R5 ack vol-up
        {3'b110, 1'b0, 8'h00, 8'h91, 1'b1},  // R2 vol-down press
        {3'b110, 1'b1, 8'hFF, 8'h81, 1'b0},  // R5 R9 ack while held
        {3'b111, 1'b0, 8'h00, 8'hA1, 1'b0},  // R3 release sets no event
        {3'b011, 1'b0, 8'h00, 8'hA3, 1'b1},  // R4 power press
        {3'b111, 1'b0, 8'h00, 8'hA1, 1'b0},  // R4 power release
        {3'b011, 1'b0, 8'h00, 8'hA3, 1'b1},  // R4 press again
        {3'b011, 1'b1, 8'h02, 8'hA1, 1'b0},  // R5 ack power while held
        {3'b100, 1'b0, 8'h00, 8'h51, 1'b1},  // R2 two volume presses
        {3'b100, 1'b1, 8'h10, 8'h41, 1'b1},  // R6 partial ack keeps irq
        {3'b100, 1'b1, 8'hBF, 8'h41, 1'b1},  // R5 R8 ones on other bits
        {3'b100, 1'b1, 8'h40, 8'h01, 1'b0},  // R6 last ack drops irq
        {3'b111, 1'b0, 8'h00, 8'hA1, 1'b0}   // R3 both released
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset reg", rd_data, 8'hA1);
        check("R1 reset irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", rd_data, 8'hA1);

        // Table walk: R2 R3 R4 R5 R6 R8 R9
        for (int i = 0; i < 16; i++) begin
            {pwr_btn_n, vup_btn_n, vdn_btn_n} = VEC[i][20:18];
            wr_en   = VEC[i][17];
            wr_data = VEC[i][16:9];
            @(negedge clk);
            wr_en = 1'b0;
            repeat (4) @(negedge clk);
            check($sformatf("R2-table step %0d reg", i), rd_data, VEC[i][8:1]);
            check($sformatf("R6 table step %0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
        end

        // R2: exact latency of a press (three edges)
        @(negedge clk);
        vup_btn_n = 1'b0;
        @(negedge clk);
        check("R2 after 1 edge", rd_data, 8'hA1);
        @(negedge clk);
        check("R2 after 2 edges", rd_data, 8'hA1);
        check("R6 irq after 2 edges", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R2 after 3 edges", rd_data, 8'h61);
        check("R6 irq after 3 edges", {7'd0, irq}, 8'h01);
        vup_btn_n = 1'b1;
        wr_en = 1'b1; wr_data = 8'h40;
        @(negedge clk);
        wr_en = 1'b0;
        check("R5 write takes one edge", rd_data, 8'h21);
        repeat (4) @(negedge clk);
        check("R3 hold back after release", rd_data, 8'hA1);

        // R7: press and clearing write in the same cycle
        vdn_btn_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h10;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 press wins", rd_data, 8'h91);
        check("R7 irq stays", {7'd0, irq}, 8'h01);
        wr_en = 1'b1; wr_data = 8'h10;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 later ack clears while held", rd_data, 8'h81);
        repeat (6) @(negedge clk);
        check("R9 held button no re-event", rd_data, 8'h81);

        // R8: writing all ones at idle changes nothing
        vdn_btn_n = 1'b1;
        repeat (5) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 fixed bits after write", rd_data, 8'hA1);
        @(negedge clk);
        check("R8 read has no side effect", rd_data, 8'hA1);

        // R1: reset in the middle of operation
        pwr_btn_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R4 power event before reset", rd_data, 8'hA3);
        pwr_btn_n = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 mid-run reset reg", rd_data, 8'hA1);
        check("R1 mid-run reset irq", {7'd0, irq}, 8'h00);

        finish_run();
    end
endmodule